// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the periodic-interrupt event of a real-time clock. A free-running binary count advances once per strobe of a 32.768 kHz clock enable. A four-bit rate code picks a power-of-two period, and an enable bit gates the output. At the end of every period the block issues a one-cycle pulse, together with an eight-bit flag-set mask. A neighbouring status register ORs that mask into its contents to raise its periodic flag and its summary interrupt flag.

Events are aligned to the free-running count. A pulse falls on the tick at which the count becomes a multiple of the period, not at a fixed delay after the settings changed. The rate code and the enable are captured only when the register file issues a restart strobe, which it does on every rewrite of either control register. New settings therefore take effect at the next aligned boundary of the new period, and the strobe never creates a pulse of its own. All pins are plain control and status signals: nothing streams in or out, so there is no handshake and no back-pressure.

Top module: `pir_rate_gen`

## Requirements
- R1: While reset is asserted and after it is released, `pulse_o` is 0 and `flag_set_o` is 0. The count restarts at 0, and the captured settings are disabled, so no pulse occurs until a restart strobe loads an enabled, non-zero code.
- R2: For a captured code c from 3 to 15, the period is 2^(c-1) ticks. A pulse follows exactly those ticks after which the 15-bit count, which starts at 0 after reset, is a multiple of the period. Two examples: code 3 gives 4 ticks and code 6 gives 32 ticks.
- R3: Codes 1 and 2 behave exactly as codes 8 and 9, giving periods of 128 and 256 ticks.
- R4: A captured code of 0, or a captured enable of 0, yields no pulse at all.
- R5: `rate_code_i` and `rate_en_i` are sampled only in a cycle with `restart_i` high. Changing them at any other time has no effect on the pulses.
- R6: If a restart strobe and a boundary tick occur in the same cycle, that tick is judged with the old settings. The new settings apply from the next tick onward, and the strobe itself never produces a pulse.
- R7: A pulse lasts one clock cycle and appears in the cycle after the clock edge that carried the boundary tick. During a pulse `flag_set_o` is 8'hC0: bit 7 is the interrupt-request flag and bit 6 is the periodic flag. At all other times it is 8'h00.
- R8: The count advances only on clock edges where `tick_en_i` is high, so a pulse only ever follows such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | One-cycle strobe at the 32.768 kHz base rate |
| rate_code_i | input | 4 | Rate-select code, sampled on restart |
| rate_en_i | input | 1 | Periodic-interrupt enable, sampled on restart |
| restart_i | input | 1 | Strobe issued whenever either control register is rewritten |
| pulse_o | output | 1 | One-cycle end-of-period event |
| flag_set_o | output | 8 | Mask to OR into the status register (8'hC0 on a pulse) |

## Verification
The bench builds the block with its default widths: a 15-bit count and a 4-bit code. With `tick_en_i` held high on every clock, even the slowest period, 16384 ticks for code 15, fits twice into a single test. The aliased codes and the count alignment are observed on the real count width rather than on a shrunken one. Toggling the tick enable exposes the gap between clock cycles and ticks. Restart strobes placed exactly on a boundary exercise the old-versus-new settings rule in both directions.

// File: rtl/pir_pkg.sv
package pir_pkg;
  // Width of the status mask handed to the flag register.
  localparam int FLAG_W   = 8;
  // Bit positions decoded by the neighbouring status register.
  localparam int IRQ_BIT  = 7;
  localparam int PER_BIT  = 6;
  // Codes up to ALIAS_MAX are folded onto slower codes by adding ALIAS_OFS.
  localparam int ALIAS_MAX = 2;
  localparam int ALIAS_OFS = 7;

  localparam logic [FLAG_W-1:0] FLAG_SET =
    FLAG_W'((1 << IRQ_BIT) | (1 << PER_BIT));
endpackage

// File: rtl/pir_cfg_latch.sv
module pir_cfg_latch #(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              en_i,
  output logic [CODE_W-1:0] code_q,
  output logic              en_q
);
  // Settings are captured only on a restart strobe and are otherwise held.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      en_q   <= 1'b0;
    end else if (restart_i) begin
      code_q <= code_i;
      en_q   <= en_i;
    end
  end
endmodule

// File: rtl/pir_rate_decode.sv
module pir_rate_decode
  import pir_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 15
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  mask_o,
  output logic              live_o
);
  logic [CODE_W-1:0] eff;
  int                eff_int;

  // Fold the two fastest codes onto slower ones.
  always_comb begin
    eff = code_i;
    if (code_i != '0 && code_i <= CODE_W'(ALIAS_MAX))
      eff = code_i + CODE_W'(ALIAS_OFS);
    eff_int = int'(eff);
  end

  // The period is 2^(eff-1); the low eff-1 count bits must be zero at a boundary.
  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign mask_o[g] = (eff_int > g + 1);
  end

  assign live_o = (code_i != '0);
endmodule

// File: rtl/pir_timebase.sv
module pir_timebase #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_q
);
  logic [CNT_W-1:0] count_nx;

  // Wraps modulo 2^CNT_W; every legal period divides the wrap evenly.
  assign count_nx = count_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (tick_i) count_q <= count_nx;
  end
endmodule

// File: rtl/pir_flag_out.sv
module pir_flag_out
  import pir_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              live_i,
  input  logic [CNT_W-1:0]  mask_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              pulse_q,
  output logic [FLAG_W-1:0] flags_q
);
  logic [CNT_W-1:0] upcoming;
  logic             hit;

  // Judge the value the count takes on this tick against the active period.
  assign upcoming = count_i + CNT_W'(1);
  assign hit      = tick_i && en_i && live_i && ((upcoming & mask_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      flags_q <= '0;
    end else begin
      pulse_q <= hit;
      flags_q <= hit ? FLAG_SET : '0;
    end
  end
endmodule

// File: rtl/pir_rate_gen.sv
module pir_rate_gen
  import pir_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic              rate_en_i,
  input  logic              restart_i,
  output logic              pulse_o,
  output logic [FLAG_W-1:0] flag_set_o
);
  logic [CODE_W-1:0] act_code;
  logic              act_en;
  logic [CNT_W-1:0]  per_mask;
  logic              code_live;
  logic [CNT_W-1:0]  count_q;

  pir_cfg_latch #(.CODE_W(CODE_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_i),
    .code_i   (rate_code_i),
    .en_i     (rate_en_i),
    .code_q   (act_code),
    .en_q     (act_en)
  );

  pir_rate_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
    .code_i(act_code),
    .mask_o(per_mask),
    .live_o(code_live)
  );

  pir_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_en_i),
    .count_q(count_q)
  );

  pir_flag_out #(.CNT_W(CNT_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_en_i),
    .en_i   (act_en),
    .live_i (code_live),
    .mask_i (per_mask),
    .count_i(count_q),
    .pulse_q(pulse_o),
    .flags_q(flag_set_o)
  );
endmodule

// File: rtl/pir_rate_gen_chk.sv
module pir_rate_gen_chk #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              restart,
  input logic              pulse,
  input logic [7:0]        flags,
  input logic              act_en,
  input logic [CODE_W-1:0] act_code,
  input logic [CNT_W-1:0]  count
);
  // R1: outputs stay quiet while reset is held.
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!pulse && flags == 8'h00)
        else $error("reset outputs not quiet");
    end
  end

  // R2: a pulse always lands on a count of at least 4-tick alignment.
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (count[1:0] == 2'b00));

  // R4: no pulse unless the settings in force before the edge were live.
  assert_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(act_en && act_code != '0));

  // R5: captured settings only move on a restart strobe.
  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ($stable(act_en) && $stable(act_code)));

  // R7: a pulse is a single cycle wide and carries the two flag bits.
  assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse ? (flags == 8'hC0) : (flags == 8'h00));

  // R8: a pulse only follows an edge that carried a tick.
  assert_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(tick_en));
endmodule

bind pir_rate_gen pir_rate_gen_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .tick_en (tick_en_i),
  .restart (restart_i),
  .pulse   (pulse_o),
  .flags   (flag_set_o),
  .act_en  (act_en),
  .act_code(act_code),
  .count   (count_q)
);

// File: tb/pir_rate_gen_tb.sv
`timescale 1ns/1ps
module pir_rate_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       rate_en = 1'b0;
  logic       restart = 1'b0;
  logic       pulse_o;
  logic [7:0] flag_set_o;

  always #2 clk = ~clk;  // 250 MHz

  pir_rate_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en),
    .rate_code_i(rate_code), .rate_en_i(rate_en), .restart_i(restart),
    .pulse_o(pulse_o), .flag_set_o(flag_set_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Period in ticks from the requirements (0 means no pulses).
  function automatic int period_of(input int c);
    if (c == 0) return 0;
    if (c == 1) return 128;
    if (c == 2) return 256;
    return 1 << (c - 1);
  endfunction

  // Reference model: tick count, captured settings, expected pulse.
  int tot = 0;
  int m_code = 0;
  bit m_en = 0;
  bit exp_p = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot = 0; m_code = 0; m_en = 0; exp_p = 0;
    end else begin
      exp_p = 0;
      if (tick_en) begin
        tot = (tot + 1) % 32768;
        if (m_en && m_code != 0 && (tot % period_of(m_code)) == 0) exp_p = 1;
      end
      if (restart) begin
        m_code = int'(rate_code);
        m_en = rate_en;
      end
    end
  end

  // Continuous comparison against the model (R2, R7).
  always @(negedge clk) begin
    if (rst_n) begin
      chk(pulse_o === exp_p, "R2 pulse vs model", int'(pulse_o), int'(exp_p));
      chk(flag_set_o === (exp_p ? 8'hC0 : 8'h00), "R7 flag mask",
          int'(flag_set_o), exp_p ? 192 : 0);
    end
  end

  task automatic apply(input int code, input bit en);
    @(negedge clk);
    rate_code = 4'(code); rate_en = en; restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic wait_pulse(input int limit, output int at, output bit ok);
    ok = 0; at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (pulse_o) begin at = tot; ok = 1; break; end
    end
  endtask

  task automatic count_pulses(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pulse_o) n++;
    end
  endtask

  localparam int NV = 8;
  localparam int V_CODE [NV] = '{3, 6, 1, 2, 10, 15, 0, 7};
  localparam bit V_EN   [NV] = '{1, 1, 1, 1, 1, 1, 1, 0};
  localparam int V_PER  [NV] = '{4, 32, 128, 256, 512, 16384, 0, 0};

  initial begin
    int a, b, n, last, prev;
    bit ok;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pulse_o == 1'b0, "R1 pulse in reset", int'(pulse_o), 0);
    chk(flag_set_o == 8'h00, "R1 flags in reset", int'(flag_set_o), 0);
    rst_n = 1'b1;
    tick_en = 1'b1;
    count_pulses(300, n);
    chk(n == 0, "R1 no pulse before restart", n, 0);

    // Table walk: R2, R3, R4
    for (int v = 0; v < NV; v++) begin
      apply(V_CODE[v], V_EN[v]);
      if (V_PER[v] == 0) begin
        count_pulses(600, n);
        chk(n == 0, "R4 disabled settings", n, 0);
      end else begin
        wait_pulse(V_PER[v] + 4, a, ok);
        chk(ok && (a % V_PER[v]) == 0, "R2 first pulse aligned", a, 0);
        wait_pulse(V_PER[v] + 4, b, ok);
        chk(ok && ((b - a + 32768) % 32768) == V_PER[v],
            (V_CODE[v] <= 2) ? "R3 aliased period" : "R2 period",
            (b - a + 32768) % 32768, V_PER[v]);
      end
    end

    // R5: input changes without restart are ignored
    apply(3, 1);
    @(negedge clk);
    rate_code = 4'd0; rate_en = 1'b0;
    count_pulses(64, n);
    chk(n == 16, "R5 held settings", n, 16);

    // R6: disable strobe on a boundary tick keeps that pulse
    while (tot % 4 != 3) @(negedge clk);
    rate_en = 1'b0; rate_code = 4'd3; restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(pulse_o == 1'b1, "R6 old settings on boundary", int'(pulse_o), 1);
    count_pulses(40, n);
    chk(n == 0, "R6 disabled afterwards", n, 0);
    // R6: enable strobe on a boundary tick gives no pulse there
    while (tot % 4 != 3) @(negedge clk);
    rate_en = 1'b1; restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(pulse_o == 1'b0, "R6 no pulse from strobe", int'(pulse_o), 0);
    count_pulses(16, n);
    chk(n == 4, "R6 new settings run", n, 4);

    // R8: ticks on every other clock double the gap in clocks
    last = -1; prev = -1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (pulse_o) begin prev = last; last = i; end
      tick_en = ~tick_en;
    end
    chk(prev >= 0 && (last - prev) == 8, "R8 gap with sparse ticks", last - prev, 8);
    tick_en = 1'b0;
    count_pulses(40, n);
    chk(n == 0, "R8 no ticks no pulses", n, 0);

    // R1: reset mid-run clears settings
    tick_en = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk(pulse_o == 1'b0 && flag_set_o == 8'h00, "R1 reset mid-run", int'(pulse_o), 0);
    rst_n = 1'b1;
    count_pulses(100, n);
    chk(n == 0, "R1 settings cleared", n, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule